// File: doc/BRIEF.md
# PCM Frame Shuttle

This block takes stereo audio, one frame per sample period, from a PCM port to a processing core and back. A 32-bit PCM input word carries two 16-bit channels: the reference noise in the low half and the corrupted signal in the high half. When the word arrives, the block splits it into a small input buffer. It then raises a one-cycle processing request. The core reads the buffer through an address port. The core reports first that it has begun and then that it has finished, and returns a 16-bit result.

An output buffer sits 16 bytes above the input buffer. It is addressed by a pointer that steps two entries at a time and wraps within four entries. When a frame is accepted, the result held from the previous frame is written at the new pointer position. That entry becomes the PCM output word once the current frame completes. This gives the stream a latency of one sample.

A word that arrives while a frame is in flight is dropped and flagged. If the core stays silent too long in the waiting state, the controller gives up, returns to idle and flags the error.

Top module: `pcm_frame_shuttle`

## Requirements
- R1: After reset, status is 2'b10, core_req, pcm_out_valid, overrun and timeout_err are 0, and every buffer entry reads 0.
- R2: When pcm_in_valid is high in idle, the word is stored in the input buffer. Bits 15:0 go to entry 0, read at BASE_ADDR. Bits 31:16 go to entry 1, read at BASE_ADDR+2. Both are readable the cycle after.
- R3: core_req is high for exactly one cycle, the cycle after a word is accepted in idle.
- R4: status bit 1 is high only in idle, meaning ready. Status bit 0 is set by core_begin in the waiting state and stays set until the controller leaves that state. Both bits are never high together.
- R5: core_done is ignored until core_begin has been seen for the current frame.
- R6: The output pointer starts at entry 1 and advances by 2 modulo 4 on each accepted frame. The result of the previous frame is written at the new position, which is read at BASE_ADDR+16+2*entry. Before any frame has completed, that result is 0.
- R7: The cycle after core_done is accepted, pcm_out_valid is high for one cycle. pcm_out_word is then {16'h0000, previous frame's result}. The controller is back in idle on the following cycle.
- R8: A word offered while not idle is dropped: the input buffer is left unchanged and overrun is set and stays set until reset.
- R9: After TIMEOUT cycles in the waiting state without an accepted core_done, the controller returns to idle. timeout_err is set and stays set, and no output word is produced.
- R10: A read address outside both buffers, or an odd address, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pcm_in_valid | input | 1 | PCM input register occupied |
| pcm_in_word | input | 32 | {corrupted, reference} samples |
| core_req | output | 1 | Processing request pulse |
| core_begin | input | 1 | Core has started the frame |
| core_done | input | 1 | Core has finished the frame |
| core_result | input | 16 | Processed sample, valid with core_done |
| buf_rd_addr | input | AW | Byte address into the shared buffers |
| buf_rd_data | output | 16 | Buffer entry at buf_rd_addr |
| status | output | 2 | Bit 1 ready/idle, bit 0 begun |
| pcm_out_valid | output | 1 | PCM output word valid |
| pcm_out_word | output | 32 | {16'h0000, sample} |
| overrun | output | 1 | Sticky dropped-word flag |
| timeout_err | output | 1 | Sticky timeout flag |

## Verification
Some properties are checked on every cycle. The request is a single-cycle pulse caused by an accepted word. The two status bits are exclusive. The output word's high half is zero and idle follows output. A word offered outside idle raises overrun, and both error flags are sticky. Other behaviour needs the bench's scenarios to show it. Stored buffer contents, the cyclic pointer and the one-sample delay across many random frames can only be seen that way. So can a done that arrives before begin being ignored, and a timeout that produces no output.

// File: rtl/pcm_frame_shuttle.sv
module pcm_frame_shuttle #(
  parameter int AW = 24,
  parameter logic [AW-1:0] BASE_ADDR = 24'h800000,
  parameter int TIMEOUT = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pcm_in_valid,
  input  logic [31:0]   pcm_in_word,
  output logic          core_req,
  input  logic          core_begin,
  input  logic          core_done,
  input  logic [15:0]   core_result,
  input  logic [AW-1:0] buf_rd_addr,
  output logic [15:0]   buf_rd_data,
  output logic [1:0]    status,
  output logic          pcm_out_valid,
  output logic [31:0]   pcm_out_word,
  output logic          overrun,
  output logic          timeout_err
);
  localparam logic [AW-1:0] OUT_ADDR = BASE_ADDR + AW'(16);
  localparam int TW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {S_IDLE, S_WORK, S_WAIT, S_DONE} st_t;
  st_t state;

  logic [15:0]   in_buf [4];
  logic [15:0]   out_buf [4];
  logic [1:0]    ptr;
  logic [15:0]   held;
  logic          begun;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      ptr <= 2'd1;
      held <= '0;
      begun <= 1'b0;
      tcnt <= '0;
      overrun <= 1'b0;
      timeout_err <= 1'b0;
      for (int i = 0; i < 4; i++) begin
        in_buf[i] <= '0;
        out_buf[i] <= '0;
      end
    end else begin
      if (pcm_in_valid && state != S_IDLE) overrun <= 1'b1;
      case (state)
        S_IDLE: if (pcm_in_valid) begin
          in_buf[0] <= pcm_in_word[15:0];
          in_buf[1] <= pcm_in_word[31:16];
          ptr <= ptr + 2'd2;
          out_buf[ptr + 2'd2] <= held;
          state <= S_WORK;
        end
        S_WORK: begin
          tcnt <= '0;
          begun <= 1'b0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (begun && core_done) begin
            held <= core_result;
            begun <= 1'b0;
            state <= S_DONE;
          end else if (tcnt == TW'(TIMEOUT - 1)) begin
            timeout_err <= 1'b1;
            begun <= 1'b0;
            state <= S_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
            if (core_begin) begun <= 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign core_req      = (state == S_WORK);
  assign status        = {state == S_IDLE, begun};
  assign pcm_out_valid = (state == S_DONE);
  assign pcm_out_word  = {16'h0000, out_buf[ptr]};

  always_comb begin
    buf_rd_data = '0;
    if (!buf_rd_addr[0]) begin
      if (buf_rd_addr[AW-1:3] == BASE_ADDR[AW-1:3]) buf_rd_data = in_buf[buf_rd_addr[2:1]];
      else if (buf_rd_addr[AW-1:3] == OUT_ADDR[AW-1:3]) buf_rd_data = out_buf[buf_rd_addr[2:1]];
    end
  end
endmodule

// File: rtl/pcm_frame_shuttle_chk.sv
module pcm_frame_shuttle_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pcm_in_valid,
  input logic        core_req,
  input logic [1:0]  status,
  input logic        pcm_out_valid,
  input logic [31:0] pcm_out_word,
  input logic        overrun,
  input logic        timeout_err
);
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |=> !core_req);
  p_req_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_req |-> ($past(pcm_in_valid) && $past(status[1])));
  p_status_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    status != 2'b11);
  p_out_hi_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_out_valid |-> (pcm_out_word[31:16] == 16'h0000));
  p_out_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_out_valid |=> (status == 2'b10));
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_in_valid && !status[1]) |=> overrun);
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> timeout_err);
endmodule

bind pcm_frame_shuttle pcm_frame_shuttle_chk chk_i (.*);

// File: tb/pcm_frame_shuttle_tb.sv
module pcm_frame_shuttle_tb_top;
  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h800000;
  localparam int TIMEOUT = 64;

  logic clk = 0, rst_n = 0;
  logic pcm_in_valid = 0, core_begin = 0, core_done = 0;
  logic [31:0] pcm_in_word = '0;
  logic [15:0] core_result = '0;
  logic [AW-1:0] buf_rd_addr = '0;
  logic core_req, pcm_out_valid, overrun, timeout_err;
  logic [15:0] buf_rd_data;
  logic [1:0] status;
  logic [31:0] pcm_out_word;

  int n_run = 0, n_fail = 0;
  logic [15:0] m_held, m_ob [4];
  logic [1:0] m_ptr;
  logic [15:0] m_in0, m_in1;

  always #4 clk = ~clk;

  pcm_frame_shuttle #(.AW(AW), .BASE_ADDR(BASE), .TIMEOUT(TIMEOUT)) dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    buf_rd_addr = a;
    #1 d = buf_rd_data;
  endtask

  function automatic logic [1:0] next_ptr(input logic [1:0] p);
    return p + 2'd2;
  endfunction

  task automatic frame(input logic [31:0] w, input int bdly, input int ddly,
                       input logic [15:0] res, input bit early_done);
    logic [15:0] d;
    @(negedge clk);
    pcm_in_valid = 1; pcm_in_word = w;
    @(negedge clk);
    pcm_in_valid = 0;
    m_in0 = w[15:0]; m_in1 = w[31:16];
    m_ptr = next_ptr(m_ptr); m_ob[m_ptr] = m_held;
    chk("R3 req", core_req, 1);
    rd(BASE, d);       chk("R2 ch0", d, m_in0);
    rd(BASE + 2, d);   chk("R2 ch1", d, m_in1);
    rd(BASE + 16 + 2*m_ptr, d); chk("R6 outbuf", d, m_held);
    @(negedge clk);
    chk("R3 req drop", core_req, 0);
    if (early_done) begin
      core_done = 1; core_result = ~res;
      @(negedge clk); core_done = 0;
      chk("R5 early done", {pcm_out_valid, status}, 3'b000);
    end
    repeat (bdly) @(negedge clk);
    core_begin = 1;
    @(negedge clk); core_begin = 0;
    chk("R4 begun", status, 2'b01);
    repeat (ddly) @(negedge clk);
    core_done = 1; core_result = res;
    @(negedge clk); core_done = 0;
    chk("R7 valid", pcm_out_valid, 1);
    chk("R7 word", pcm_out_word, {16'h0, m_ob[m_ptr]});
    chk("R4 begun clr", status[0], 0);
    m_held = res;
    @(negedge clk);
    chk("R7 idle", {pcm_out_valid, status}, 3'b010);
  endtask

  initial begin
    logic [15:0] d;
    bit saw_out;
    void'($urandom(32'h5EED));
    m_held = 0; m_ptr = 2'd1;
    for (int i = 0; i < 4; i++) m_ob[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", status, 2'b10);
    chk("R1 flags", {core_req, pcm_out_valid, overrun, timeout_err}, 4'b0);
    for (int i = 0; i < 4; i++) begin
      rd(BASE + 2*i, d);      chk("R1 inbuf", d, 0);
      rd(BASE + 16 + 2*i, d); chk("R1 outbuf", d, 0);
    end

    frame(32'hAAAA_5555, 0, 0, 16'h1234, 0);
    frame(32'h0102_0304, 2, 3, 16'hBEEF, 1);
    rd(BASE + 3, d);    chk("R10 odd", d, 0);
    rd(BASE + 8, d);    chk("R10 gap", d, 0);
    rd(BASE - 2, d);    chk("R10 below", d, 0);
    rd(BASE + 24, d);   chk("R10 above", d, 0);

    for (int k = 0; k < 30; k++)
      frame($urandom, $urandom_range(0, 5), $urandom_range(0, 5), 16'($urandom), $urandom_range(0, 1) == 1);

    // R8 overrun during a frame
    @(negedge clk);
    pcm_in_valid = 1; pcm_in_word = 32'hCAFE_F00D;
    @(negedge clk);
    m_ptr = next_ptr(m_ptr); m_ob[m_ptr] = m_held;
    pcm_in_word = 32'h1111_2222;
    @(negedge clk);
    pcm_in_valid = 0;
    chk("R8 overrun", overrun, 1);
    rd(BASE, d);      chk("R8 ch0 kept", d, 16'hF00D);
    rd(BASE + 2, d);  chk("R8 ch1 kept", d, 16'hCAFE);
    // R9 timeout: no begin issued
    saw_out = 0;
    for (int c = 0; c < TIMEOUT + 4; c++) begin
      @(negedge clk);
      if (pcm_out_valid) saw_out = 1;
    end
    chk("R9 idle", status, 2'b10);
    chk("R9 err", timeout_err, 1);
    chk("R9 no out", saw_out, 0);
    chk("R8 sticky", overrun, 1);

    frame(32'h7777_8888, 1, 1, 16'h4242, 0);
    chk("R9 sticky", timeout_err, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule